// File: doc/BRIEF.md
# Palette PWM Dot-Matrix Scanner

This block drives a multiplexed LED dot matrix. It selects one row at a time and drives the column enables of that row with pulse-width modulation. Each dot is stored as a 4-bit word in an external two-page pixel memory. The block reads that memory through a request/response port. The lower three bits of a dot pick one of seven shared 6-bit palette duty values, or pick "off". The top bit lets the dot take part in the global blink or brightness-inversion effect. Above the per-dot brightness, the block applies a global brightness ceiling, row and column masks, a global blank and blanking from a ring-tone sync input. It can also alternate the two pages automatically.

A row slot is 64 PWM steps of `STEP_CYCLES` clocks each. During a slot the block prefetches the dots of the row that comes next. At the row boundary it converts every dot of that row into a column duty and holds those duties for the whole slot. A column is lit for the first `duty` steps of the slot. Every setting is therefore sampled only at row boundaries. Blink and auto-page timing count pulses on `ms_tick`, which is expected to be a 1 ms strobe. The pixel-memory request side uses valid/ready. The block raises `mem_req_valid` only during PWM steps 0 to 61 of a slot. Once raised, the request keeps its address until it is accepted. The one exception is the end of the fetch window, where an unaccepted request is withdrawn and that dot shows dark for the coming row. The memory returns the addressed word on `mem_rsp_data` in the cycle after the handshake and cannot apply back-pressure to the response.

Top module: `dot_matrix_scanner`

## Requirements
- R1: After reset, row 0 is selected and all columns are off, and the whole first row slot stays dark.
- R2: Exactly one row output is high at all times. Rows advance in ascending order and wrap to 0 after the last active row. Each slot lasts 64 × `STEP_CYCLES` clocks.
- R3: Dot code 0 is dark. Code k (1 to 7) uses palette entry k at `cfg_palette[6k-1:6k-6]`. A palette value n gives a duty of n+1 steps out of 64, except that n = 0 gives 0. A column with duty d is on for the first d steps of its slot.
- R4: The duty is limited to `cfg_max_duty` steps, and the value 63 means no limit (64 steps).
- R5: When `cfg_row_mask_en` is 1, a row whose `cfg_row_mask` bit is 1 is dark. When `cfg_col_mask_en` is 1, a column whose `cfg_col_mask` bit is 1 is dark. A mask has no effect while its enable is 0.
- R6: `cfg_all_off` = 1 darkens every dot. When `cfg_sync_bypass` = 0, `sync_in` = 0 darkens every dot and `sync_in` = 1 gives normal display.
- R7: Flash timing starts in its first half when `cfg_blink_en` rises. The phase toggles every 50 × (`cfg_blink_code`+1) ticks. In the second half, with `cfg_invert` = 0, any dot whose bit 3 is 1 is dark.
- R8: With `cfg_invert` = 1, a flagged dot with code 1 to 7 shows 64 minus its palette duty in the second half, before the R4 limit is applied. Code 0 stays dark.
- R9: Page `cfg_page` is displayed. When `cfg_autopage_en` is 1, the displayed page is inverted during every other period of 50 × (`cfg_autopage_code`+1) ticks, counted from the enable.
- R10: With `cfg_reduced` = 1, only rows 0 to 4 are scanned and columns 15 and up stay dark.
- R11: A read address is {page, row[2:0], column[4:0]}. A request keeps a stable address until it is accepted, and the response word is taken one cycle after the handshake.
- R12: Settings and dot data are sampled only at row boundaries, so no column turns on in the middle of a slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ms_tick | input | 1 | One-cycle millisecond strobe |
| cfg_reduced | input | 1 | 1 = 5 × 15 layout |
| cfg_page | input | 1 | Displayed page |
| cfg_autopage_en | input | 1 | Automatic page alternation |
| cfg_autopage_code | input | 4 | Page period code |
| cfg_blink_en | input | 1 | Global enable of the per-dot flash effect |
| cfg_invert | input | 1 | 0 = blink, 1 = brightness inversion |
| cfg_blink_code | input | 4 | Flash half-period code |
| cfg_palette | input | 42 | Seven 6-bit palette duty values |
| cfg_max_duty | input | 6 | Brightness ceiling |
| cfg_row_mask_en | input | 1 | Row mask enable |
| cfg_row_mask | input | 7 | Row mask, 1 = dark |
| cfg_col_mask_en | input | 1 | Column mask enable |
| cfg_col_mask | input | 17 | Column mask, 1 = dark |
| cfg_all_off | input | 1 | Global blank |
| cfg_sync_bypass | input | 1 | 0 = ring-tone sync blanking active |
| sync_in | input | 1 | Ring-tone sync level |
| mem_req_valid | output | 1 | Pixel read request valid |
| mem_req_ready | input | 1 | Pixel memory accepts the request |
| mem_req_addr | output | 9 | Pixel read address |
| mem_rsp_data | input | 4 | Dot word, one cycle after the handshake |
| row_on | output | 7 | One-hot row select |
| col_on | output | 17 | Column enables |

## Verification
The bench measures each column's on-time over whole slots and goes after the edges of the duty arithmetic. These edges are palette value 0 (a design that forgets the special case lights the dot for one step), the ceiling value 63 (a design without the special case loses a step), and inversion, which gives 64 for a zero palette entry. It counts ticks exactly to the flash and page half-period boundaries, so a timer that is off by one shows the wrong phase. It applies masks with their enables both off and on, and uses the reduced layout to catch a scan that still visits rows 5 and 6 or lights the upper columns. Random memory stalls test that dots are still fetched into the right columns. A blank set in the middle of a slot must not cut that slot short.

// File: rtl/dms_pkg.sv
package dms_pkg;
  localparam int PWM_STEPS   = 64;
  localparam int PAL_BITS    = 6;
  localparam int PAL_ENTRIES = 7;
  localparam int DUTY_W      = 7;
  localparam int DOT_W       = 4;

  typedef struct packed {
    logic       flash;
    logic [2:0] code;
  } dot_t;

  function automatic logic [DUTY_W-1:0] palette_duty(input logic [PAL_BITS-1:0] n);
    return (n == '0) ? '0 : DUTY_W'(n) + DUTY_W'(1);
  endfunction

  function automatic logic [DUTY_W-1:0] ceiling_duty(input logic [PAL_BITS-1:0] m);
    return (m == '1) ? DUTY_W'(PWM_STEPS) : DUTY_W'(m);
  endfunction
endpackage

// File: rtl/dms_half_timer.sv
module dms_half_timer #(
  parameter int UNIT = 50
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       tick,
  input  logic [3:0] code,
  output logic       phase
);
  localparam int CNT_W = $clog2(UNIT * 16 + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;

  assign limit = CNT_W'(UNIT) * (CNT_W'(code) + CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      phase <= 1'b0;
    end else if (!en) begin
      cnt_q <= '0;
      phase <= 1'b0;
    end else if (tick) begin
      if (cnt_q + CNT_W'(1) >= limit) begin
        cnt_q <= '0;
        phase <= ~phase;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/dms_dot_duty.sv
module dms_dot_duty
  import dms_pkg::*;
(
  input  dot_t                            dot,
  input  logic [PAL_ENTRIES*PAL_BITS-1:0] palette,
  input  logic                            flash_on,
  input  logic                            phase,
  input  logic                            invert,
  input  logic [PAL_BITS-1:0]             max_duty,
  output logic [DUTY_W-1:0]               duty
);
  logic [DUTY_W-1:0] base;
  logic [DUTY_W-1:0] shown;
  logic [DUTY_W-1:0] lim;

  always_comb begin
    base = '0;
    if (dot.code != 3'd0)
      base = palette_duty(palette[(int'(dot.code) - 1) * PAL_BITS +: PAL_BITS]);
    shown = base;
    if (dot.code != 3'd0 && flash_on && dot.flash && phase)
      shown = invert ? (DUTY_W'(PWM_STEPS) - base) : '0;
    lim  = ceiling_duty(max_duty);
    duty = (shown < lim) ? shown : lim;
  end
endmodule

// File: rtl/dms_row_fetch.sv
module dms_row_fetch
  import dms_pkg::*;
#(
  parameter int COLS = 17,
  parameter int RW   = 3,
  parameter int CW   = 5,
  parameter int AW   = 9
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  restart,
  input  logic                  allow,
  input  logic [RW-1:0]         row_sel,
  input  logic                  page_sel,
  output logic                  req_valid,
  input  logic                  req_ready,
  output logic [AW-1:0]         req_addr,
  input  logic [DOT_W-1:0]      rsp_data,
  output logic [COLS*DOT_W-1:0] dots_flat
);
  localparam int FCW = $clog2(COLS + 1);

  logic [FCW-1:0]   fc_q;
  logic [RW-1:0]    row_q;
  logic             page_q;
  logic             pend_q;
  logic [CW-1:0]    pend_idx_q;
  logic [DOT_W-1:0] dbuf_q [COLS];

  assign req_valid = allow && (fc_q < FCW'(COLS));
  assign req_addr  = {page_q, row_q, fc_q[CW-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fc_q       <= '0;
      row_q      <= RW'(1);
      page_q     <= 1'b0;
      pend_q     <= 1'b0;
      pend_idx_q <= '0;
      for (int c = 0; c < COLS; c++) dbuf_q[c] <= '0;
    end else if (restart) begin
      fc_q   <= '0;
      row_q  <= row_sel;
      page_q <= page_sel;
      pend_q <= 1'b0;
      for (int c = 0; c < COLS; c++) dbuf_q[c] <= '0;
    end else begin
      pend_q <= req_valid && req_ready;
      if (req_valid && req_ready) begin
        fc_q       <= fc_q + FCW'(1);
        pend_idx_q <= fc_q[CW-1:0];
      end
      if (pend_q) dbuf_q[pend_idx_q] <= rsp_data;
    end
  end

  for (genvar c = 0; c < COLS; c++) begin : g_flat
    assign dots_flat[c*DOT_W +: DOT_W] = dbuf_q[c];
  end
endmodule

// File: rtl/dot_matrix_scanner.sv
module dot_matrix_scanner
  import dms_pkg::*;
#(
  parameter int ROWS        = 7,
  parameter int COLS        = 17,
  parameter int RED_ROWS    = 5,
  parameter int RED_COLS    = 15,
  parameter int STEP_CYCLES = 8,
  parameter int MS_UNIT     = 50
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               ms_tick,
  input  logic                               cfg_reduced,
  input  logic                               cfg_page,
  input  logic                               cfg_autopage_en,
  input  logic [3:0]                         cfg_autopage_code,
  input  logic                               cfg_blink_en,
  input  logic                               cfg_invert,
  input  logic [3:0]                         cfg_blink_code,
  input  logic [PAL_ENTRIES*PAL_BITS-1:0]    cfg_palette,
  input  logic [PAL_BITS-1:0]                cfg_max_duty,
  input  logic                               cfg_row_mask_en,
  input  logic [ROWS-1:0]                    cfg_row_mask,
  input  logic                               cfg_col_mask_en,
  input  logic [COLS-1:0]                    cfg_col_mask,
  input  logic                               cfg_all_off,
  input  logic                               cfg_sync_bypass,
  input  logic                               sync_in,
  output logic                               mem_req_valid,
  input  logic                               mem_req_ready,
  output logic [$clog2(ROWS)+$clog2(COLS):0] mem_req_addr,
  input  logic [DOT_W-1:0]                   mem_rsp_data,
  output logic [ROWS-1:0]                    row_on,
  output logic [COLS-1:0]                    col_on
);
  localparam int RW         = $clog2(ROWS);
  localparam int CW         = $clog2(COLS);
  localparam int AW         = 1 + RW + CW;
  localparam int DIVW       = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;
  localparam int SW         = $clog2(PWM_STEPS);
  localparam int FETCH_STOP = PWM_STEPS - 2;

  function automatic logic [RW-1:0] next_row(input logic [RW-1:0] r, input logic red);
    int last;
    last = red ? RED_ROWS - 1 : ROWS - 1;
    return (int'(r) >= last) ? '0 : RW'(r + RW'(1));
  endfunction

  logic [DIVW-1:0]        div_q;
  logic [SW-1:0]          step_q;
  logic [RW-1:0]          row_q;
  logic                   step_end;
  logic                   boundary;
  logic [RW-1:0]          row_enter;
  logic                   flash_phase;
  logic                   page_phase;
  logic [COLS*DOT_W-1:0]  dots_flat;
  logic                   blank_all;
  logic [DUTY_W-1:0]      duty_q [COLS];

  assign step_end  = (div_q == DIVW'(STEP_CYCLES - 1));
  assign boundary  = step_end && (step_q == SW'(PWM_STEPS - 1));
  assign row_enter = next_row(row_q, cfg_reduced);
  assign blank_all = cfg_all_off || (!cfg_sync_bypass && !sync_in)
                   || (cfg_row_mask_en && cfg_row_mask[row_enter]);
  assign row_on    = ROWS'(1) << row_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      step_q <= '0;
      row_q  <= '0;
    end else begin
      div_q <= step_end ? '0 : div_q + DIVW'(1);
      if (step_end) step_q <= step_q + SW'(1);
      if (boundary) row_q <= row_enter;
    end
  end

  dms_half_timer #(.UNIT(MS_UNIT)) u_flash_timer (
    .clk(clk), .rst_n(rst_n), .en(cfg_blink_en), .tick(ms_tick),
    .code(cfg_blink_code), .phase(flash_phase)
  );

  dms_half_timer #(.UNIT(MS_UNIT)) u_page_timer (
    .clk(clk), .rst_n(rst_n), .en(cfg_autopage_en), .tick(ms_tick),
    .code(cfg_autopage_code), .phase(page_phase)
  );

  dms_row_fetch #(.COLS(COLS), .RW(RW), .CW(CW), .AW(AW)) u_fetch (
    .clk(clk), .rst_n(rst_n), .restart(boundary),
    .allow(step_q < SW'(FETCH_STOP)),
    .row_sel(next_row(row_enter, cfg_reduced)),
    .page_sel(cfg_page ^ page_phase),
    .req_valid(mem_req_valid), .req_ready(mem_req_ready), .req_addr(mem_req_addr),
    .rsp_data(mem_rsp_data), .dots_flat(dots_flat)
  );

  for (genvar c = 0; c < COLS; c++) begin : g_col
    logic [DUTY_W-1:0] dot_duty;
    logic              col_dark;

    dms_dot_duty u_duty (
      .dot(dot_t'(dots_flat[c*DOT_W +: DOT_W])), .palette(cfg_palette),
      .flash_on(cfg_blink_en), .phase(flash_phase), .invert(cfg_invert),
      .max_duty(cfg_max_duty), .duty(dot_duty)
    );

    assign col_dark = blank_all || (cfg_col_mask_en && cfg_col_mask[c])
                    || (cfg_reduced && (c >= RED_COLS));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        duty_q[c] <= '0;
      else if (boundary) duty_q[c] <= col_dark ? '0 : dot_duty;
    end

    assign col_on[c] = {1'b0, step_q} < duty_q[c];
  end
endmodule

// File: rtl/dms_checker.sv
module dms_checker #(
  parameter int ROWS     = 7,
  parameter int COLS     = 17,
  parameter int RED_ROWS = 5,
  parameter int RED_COLS = 15,
  parameter int AW       = 9
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_all_off,
  input logic            cfg_reduced,
  input logic            mem_req_valid,
  input logic            mem_req_ready,
  input logic [AW-1:0]   mem_req_addr,
  input logic [ROWS-1:0] row_on,
  input logic [COLS-1:0] col_on
);
  // R2
  row_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(row_on) == 1);

  // R12
  mid_slot_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(col_on & ~$past(col_on))) |-> !$stable(row_on));

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (!mem_req_valid || $stable(mem_req_addr)));

  // R6
  all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(row_on) && $past(cfg_all_off)) |-> (col_on == '0));

  // R10
  reduced_rows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(row_on) && $past(cfg_reduced)) |-> (row_on < ROWS'(1 << RED_ROWS)));

  // R10
  reduced_cols_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(row_on) && $past(cfg_reduced)) |-> ((col_on >> RED_COLS) == '0));
endmodule

bind dot_matrix_scanner dms_checker #(
  .ROWS(ROWS), .COLS(COLS), .RED_ROWS(RED_ROWS), .RED_COLS(RED_COLS), .AW(AW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_all_off(cfg_all_off), .cfg_reduced(cfg_reduced),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .row_on(row_on), .col_on(col_on)
);

// File: tb/dot_matrix_scanner_test.sv
`timescale 1ns/1ps
module dot_matrix_scanner_test;
  localparam int ROWS = 7;
  localparam int COLS = 17;
  localparam int DIV  = 2;
  localparam int SLOT = 64 * DIV;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ms_tick = 1'b0;
  logic cfg_reduced = 0, cfg_page = 0, cfg_autopage_en = 0, cfg_blink_en = 0, cfg_invert = 0;
  logic [3:0] cfg_autopage_code = 0, cfg_blink_code = 0;
  logic [41:0] cfg_palette = 0;
  logic [5:0] cfg_max_duty = 6'd63;
  logic cfg_row_mask_en = 0, cfg_col_mask_en = 0, cfg_all_off = 0, cfg_sync_bypass = 1, sync_in = 0;
  logic [ROWS-1:0] cfg_row_mask = 0;
  logic [COLS-1:0] cfg_col_mask = 0;
  logic mem_req_valid, mem_req_ready = 1'b1;
  logic [8:0] mem_req_addr;
  logic [3:0] mem_rsp_data = 4'h0;
  logic [ROWS-1:0] row_on;
  logic [COLS-1:0] col_on;

  logic [3:0] mem [0:511];
  int errors = 0, checks = 0;
  bit done = 0;
  bit flash_ph = 0, page_ph = 0;
  int meas [COLS];
  int meas_row;

  always #5 clk = ~clk;

  dot_matrix_scanner #(.STEP_CYCLES(DIV), .MS_UNIT(50)) uut (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .cfg_reduced(cfg_reduced),
    .cfg_page(cfg_page), .cfg_autopage_en(cfg_autopage_en), .cfg_autopage_code(cfg_autopage_code),
    .cfg_blink_en(cfg_blink_en), .cfg_invert(cfg_invert), .cfg_blink_code(cfg_blink_code),
    .cfg_palette(cfg_palette), .cfg_max_duty(cfg_max_duty),
    .cfg_row_mask_en(cfg_row_mask_en), .cfg_row_mask(cfg_row_mask),
    .cfg_col_mask_en(cfg_col_mask_en), .cfg_col_mask(cfg_col_mask),
    .cfg_all_off(cfg_all_off), .cfg_sync_bypass(cfg_sync_bypass), .sync_in(sync_in),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_data(mem_rsp_data), .row_on(row_on), .col_on(col_on)
  );

  // Pixel memory model: word returned one cycle after the handshake (R11)
  always @(posedge clk) if (mem_req_valid && mem_req_ready) mem_rsp_data <= mem[mem_req_addr];
  always @(negedge clk) mem_req_ready <= ($urandom % 4) != 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int row_idx();
    for (int i = 0; i < ROWS; i++) if (row_on[i]) return i;
    return -1;
  endfunction

  function automatic int exp_duty(int r, int c, bit ignore_off);
    logic [3:0] d;
    int base, lim, n;
    d = mem[{cfg_page ^ page_ph, 3'(r), 5'(c)}];
    if (cfg_all_off && !ignore_off) return 0;
    if (!cfg_sync_bypass && !sync_in) return 0;
    if (cfg_row_mask_en && cfg_row_mask[r]) return 0;
    if (cfg_col_mask_en && cfg_col_mask[c]) return 0;
    if (cfg_reduced && c >= 15) return 0;
    if (d[2:0] == 0) return 0;
    n = int'(cfg_palette[(int'(d[2:0]) - 1) * 6 +: 6]);
    base = (n == 0) ? 0 : n + 1;
    if (cfg_blink_en && d[3] && flash_ph) base = cfg_invert ? 64 - base : 0;
    lim = (cfg_max_duty == 63) ? 64 : int'(cfg_max_duty);
    return (base < lim) ? base : lim;
  endfunction

  task automatic wait_boundary();
    logic [ROWS-1:0] prev;
    prev = row_on;
    do @(negedge clk); while (row_on == prev);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      ms_tick = 1'b1;
      @(negedge clk);
      ms_tick = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic measure(input int flip_at);
    wait_boundary();
    wait_boundary();
    meas_row = row_idx();
    for (int c = 0; c < COLS; c++) meas[c] = 0;
    for (int i = 0; i < SLOT; i++) begin
      if (i == flip_at) cfg_all_off = 1'b1;
      for (int c = 0; c < COLS; c++) meas[c] += int'(col_on[c]);
      @(negedge clk);
    end
  endtask

  task automatic compare(input string tag, input bit ignore_off);
    for (int c = 0; c < COLS; c++)
      check(meas[c] == exp_duty(meas_row, c, ignore_off) * DIV, tag,
            meas[c] / DIV, exp_duty(meas_row, c, ignore_off));
  endtask

  task automatic run(input string tag, input int n);
    for (int k = 0; k < n; k++) begin
      measure(-1);
      compare(tag, 0);
    end
  endtask

  task automatic scan_order(input string tag, input int nrows);
    int cur, len;
    logic [ROWS-1:0] prev;
    wait_boundary();
    for (int k = 0; k < nrows + 2; k++) begin
      cur = row_idx();
      prev = row_on;
      len = 0;
      do begin @(negedge clk); len++; end while (row_on == prev);
      check(len == SLOT, tag, len, SLOT);
      check(row_idx() == (cur + 1) % nrows, tag, row_idx(), (cur + 1) % nrows);
    end
  endtask

  task automatic randomize_mem();
    for (int a = 0; a < 512; a++) mem[a] = 4'($urandom);
  endtask

  task automatic randomize_palette();
    for (int k = 0; k < 7; k++) cfg_palette[k*6 +: 6] = 6'($urandom);
    cfg_palette[($urandom % 7) * 6 +: 6] = 6'd0;
    cfg_palette[($urandom % 7) * 6 +: 6] = 6'd63;
  endtask

  initial begin
    int sum;
    void'($urandom(32'h5EED_0042));
    randomize_mem();
    randomize_palette();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state and a dark first slot
    check(row_on == 7'd1, "R1 row", int'(row_on), 1);
    check(col_on == '0, "R1 cols", int'(col_on), 0);
    sum = 0;
    while (row_on == 7'd1) begin sum += int'($countones(col_on)); @(negedge clk); end
    check(sum == 0, "R1 first slot dark", sum, 0);

    // R2: scan order and slot length
    scan_order("R2", ROWS);

    // R3 R11: random palettes and dots under random stalls
    for (int it = 0; it < 5; it++) begin
      randomize_mem();
      randomize_palette();
      run("R3 R11 random", 2);
    end

    // R4: brightness ceiling
    cfg_max_duty = 6'd0;  run("R4 ceiling 0", 1);
    cfg_max_duty = 6'd5;  run("R4 ceiling 5", 1);
    cfg_max_duty = 6'd62; run("R4 ceiling 62", 1);
    cfg_max_duty = 6'd63;

    // R5: masks, enables off then on
    cfg_row_mask = 7'b1010101; cfg_col_mask = 17'h0A5C3;
    run("R5 masks disabled", 2);
    cfg_row_mask_en = 1; run("R5 row mask", 3);
    cfg_row_mask_en = 0; cfg_col_mask_en = 1; run("R5 col mask", 2);
    cfg_col_mask_en = 0;

    // R6: global blank and sync blanking
    cfg_all_off = 1; run("R6 all off", 1);
    cfg_all_off = 0; cfg_sync_bypass = 0; sync_in = 0; run("R6 sync low", 1);
    sync_in = 1; run("R6 sync high", 1);
    cfg_sync_bypass = 1;

    // R7: blink timing and off half
    cfg_blink_code = 4'd0; cfg_blink_en = 1; flash_ph = 0;
    run("R7 first half", 1);
    ticks(49); run("R7 before toggle", 1);
    ticks(1); flash_ph = 1; run("R7 off half", 1);
    cfg_blink_en = 0; flash_ph = 0; @(negedge clk);
    cfg_blink_code = 4'd2; cfg_blink_en = 1;
    ticks(149); run("R7 code2 first half", 1);
    ticks(1); flash_ph = 1; run("R7 code2 off half", 1);

    // R8: inversion in the second half, then back to normal
    cfg_invert = 1; run("R8 inverted", 2);
    ticks(150); flash_ph = 0; run("R8 normal half", 1);
    cfg_blink_en = 0; cfg_invert = 0;

    // R9: page select and automatic alternation
    cfg_page = 1; run("R9 page 1", 1);
    cfg_autopage_code = 4'd1; cfg_autopage_en = 1;
    ticks(99); run("R9 auto before toggle", 1);
    ticks(1); page_ph = 1; run("R9 auto toggled", 2);
    cfg_autopage_en = 0; page_ph = 0; cfg_page = 0;

    // R10: reduced layout
    cfg_reduced = 1;
    wait_boundary(); wait_boundary();
    scan_order("R10 rows", 5);
    run("R10 cols", 3);
    cfg_reduced = 0;

    // R12: blank raised mid-slot must wait for the boundary
    measure(20);
    compare("R12 mid-slot", 1);
    run("R12 next slot dark", 1);
    cfg_all_off = 0;

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1_900_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule